// File: doc/BRIEF.md
# Multi-Port Bus Halt Controller

This block brings a set of bus master ports to a quiet state one after another, as part of shutting a subsystem down or cleaning up after it failed to boot. Each port offers three signals to the controller: a halt request that the controller drives, and a halt acknowledge and an idle indication that the port returns. With the default of three ports, they are handled in a fixed sequence: the processor port (index 0), then the modem port (index 1), then the non-coherent port (index 2).

A single start pulse launches the sequence. For every port the controller first looks at its idle signal. A port that is already idle is passed over without a request. Otherwise the request is raised and held. The acknowledge is sampled only on a free-running millisecond tick, and the request is held until the acknowledge is seen or a tick budget runs out. The idle signal is then read again. A port that is still busy gets its failure flag set. The request is withdrawn in either case; the port itself is expected to stay halted until its own reset. After the last port, a done level is raised.

Top module: `bus_halt_ctrl`

## Requirements
- R1: While rst_n is low and in the cycle after it rises, halt_req_o, fail_o and done_o are all zero.
- R2: A start_i pulse in the idle or done state clears fail_o and done_o on the next clock edge and begins with port 0. A start_i pulse while a sequence is running has no effect on halt_req_o, fail_o or the port sequence.
- R3: Ports are served strictly in index order 0, 1, 2, and at most one bit of halt_req_o is high in any cycle.
- R4: A port whose bus_idle_i bit is 1 when its turn comes is skipped: its halt_req_o bit never rises in that sequence.
- R5: Once raised, a port's request stays high until a cycle in which tick_i and that port's halt_ack_i are both 1. The acknowledge is only looked at in cycles with tick_i high.
- R6: If TIMEOUT_TICKS ticks (default 100) pass without an acknowledge, the wait ends on the last of those ticks. The tick count restarts for every port.
- R7: In the cycle after the wait ends, the port's bus_idle_i is sampled; a 0 sets that port's fail_o bit, which then holds until the next accepted start.
- R8: The request bit is cleared on the clock edge that follows the wait, whether the idle check passed or failed.
- R9: done_o rises after the last port has been handled (served or skipped) and stays high, with no request active, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches the halt sequence |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| halt_ack_i | input | NUM_PORTS | Per-port halt acknowledge |
| bus_idle_i | input | NUM_PORTS | Per-port idle indication |
| halt_req_o | output | NUM_PORTS | Per-port halt request |
| done_o | output | 1 | Sequence complete, held until the next start |
| fail_o | output | NUM_PORTS | Per-port flag: still busy after the wait |

## Verification
The assertions assume that start_i and tick_i are single-cycle pulses. They also assume that acknowledge and idle are ordinary synchronous levels, without any requirement on how they relate to the request. The bench drives every input on the falling clock edge. It produces the tick from a divider as a one-cycle pulse every fourth cycle. A port model raises acknowledge only while that port's request is high, and only after a set number of ticks. A port that has acknowledged reports itself idle only when the scenario asks for it, so both the passing and the failing idle checks are reached.

// File: rtl/bhc_pkg.sv
// Package for the bus halt controller: sequencer state encoding.
// Assumes nothing beyond being compiled before its users.
package bhc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROBE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CHECK = 3'd3,
        ST_DONE  = 3'd4
    } bhc_state_e;
endpackage

// File: rtl/bhc_wait_timer.sv
// Tick-based wait timer. Counts tick pulses while run_i is high and flags
// the tick on which LIMIT ticks have elapsed. Clears whenever run_i is low,
// so each wait starts from zero. Assumes tick_i is a single-cycle pulse.
module bhc_wait_timer #(
    parameter int LIMIT = 100,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_q;

    // Expiry is the LIMIT-th tick of the current wait.
    always_comb expire_o = run_i && tick_i && (cnt_q == CNT_W'(LIMIT - 1));

    // Advance on ticks, clear when idle or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/bhc_port_select.sv
// Port selection: picks the acknowledge and idle bits of the active port
// and builds the one-hot request mask for it. Purely combinational.
// Assumes idx_i is below NUM_PORTS.
module bhc_port_select #(
    parameter int NUM_PORTS = 3,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [NUM_PORTS-1:0] ack_i,
    input  logic [NUM_PORTS-1:0] idle_i,
    output logic                 sel_ack_o,
    output logic                 sel_idle_o,
    output logic [NUM_PORTS-1:0] mask_o
);
    logic [NUM_PORTS-1:0] hit;

    // One decode line per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        assign hit[p] = (idx_i == IDX_W'(p));
    end

    // Gate the port signals with the decode and reduce.
    always_comb begin
        sel_ack_o  = |(hit & ack_i);
        sel_idle_o = |(hit & idle_i);
        mask_o     = hit;
    end
endmodule

// File: rtl/bus_halt_ctrl.sv
// Multi-port bus halt controller. On start, visits each port in index
// order: an idle port is skipped; otherwise a halt request is held until an
// acknowledge is seen on a tick or TIMEOUT_TICKS ticks pass, idle is then
// re-checked (a busy port sets its fail flag) and the request is dropped.
// done_o is raised after the last port. Assumes start_i and tick_i are
// single-cycle pulses and that port inputs are synchronous to clk.
module bus_halt_ctrl #(
    parameter int NUM_PORTS     = 3,
    parameter int TIMEOUT_TICKS = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 tick_i,
    input  logic [NUM_PORTS-1:0] halt_ack_i,
    input  logic [NUM_PORTS-1:0] bus_idle_i,
    output logic [NUM_PORTS-1:0] halt_req_o,
    output logic                 done_o,
    output logic [NUM_PORTS-1:0] fail_o
);
    import bhc_pkg::*;

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

    bhc_state_e           state_q;
    logic [IDX_W-1:0]     port_idx_q;
    logic [NUM_PORTS-1:0] req_q;
    logic [NUM_PORTS-1:0] fail_q;
    logic                 sel_ack;
    logic                 sel_idle;
    logic [NUM_PORTS-1:0] port_mask;
    logic                 waiting;
    logic                 expire;
    logic [CNT_W-1:0]     wait_cnt;
    logic                 wait_over;
    logic                 start_ok;
    logic                 at_last;

    bhc_port_select #(.NUM_PORTS(NUM_PORTS)) sel_i (
        .idx_i      (port_idx_q),
        .ack_i      (halt_ack_i),
        .idle_i     (bus_idle_i),
        .sel_ack_o  (sel_ack),
        .sel_idle_o (sel_idle),
        .mask_o     (port_mask)
    );

    bhc_wait_timer #(.LIMIT(TIMEOUT_TICKS)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (waiting),
        .tick_i   (tick_i),
        .expire_o (expire),
        .count_o  (wait_cnt)
    );

    // Wait ends on a tick that sees the acknowledge, or on timer expiry.
    always_comb begin
        waiting   = (state_q == ST_WAIT);
        wait_over = waiting && ((tick_i && sel_ack) || expire);
        start_ok  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
        at_last   = (port_idx_q == LAST_IDX);
    end

    // Sequencer: state, port index, requests and fail flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            port_idx_q <= '0;
            req_q      <= '0;
            fail_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        state_q    <= ST_PROBE;
                        port_idx_q <= '0;
                        fail_q     <= '0;
                    end
                end
                ST_PROBE: begin
                    if (sel_idle) begin
                        if (at_last) begin
                            state_q <= ST_DONE;
                        end else begin
                            port_idx_q <= port_idx_q + 1'b1;
                        end
                    end else begin
                        req_q   <= port_mask;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_over) begin
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!sel_idle) begin
                        fail_q <= fail_q | port_mask;
                    end
                    req_q <= '0;
                    if (at_last) begin
                        state_q <= ST_DONE;
                    end else begin
                        port_idx_q <= port_idx_q + 1'b1;
                        state_q    <= ST_PROBE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign halt_req_o = req_q;
    assign fail_o     = fail_q;
    assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/bus_halt_ctrl_chk.sv
// Property checker for bus_halt_ctrl, attached by bind. Observes the ports
// plus the sequencer state, port index and wait counter.
module bus_halt_ctrl_chk #(
    parameter int NUM_PORTS     = 3,
    parameter int TIMEOUT_TICKS = 100,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   tick_i,
    input logic [NUM_PORTS-1:0]   bus_idle_i,
    input logic [NUM_PORTS-1:0]   halt_req_o,
    input logic                   done_o,
    input logic [NUM_PORTS-1:0]   fail_o,
    input bhc_pkg::bhc_state_e    state,
    input logic [IDX_W-1:0]       port_idx,
    input logic [CNT_W-1:0]       wait_cnt
);
    import bhc_pkg::*;

    logic cur_idle;
    assign cur_idle = bus_idle_i[port_idx];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (halt_req_o == '0 && fail_o == '0 && !done_o));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (state == ST_IDLE || state == ST_DONE)) |=> (fail_o == '0 && !done_o));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state == ST_WAIT) |=> $stable(halt_req_o) && $stable(fail_o));

    // R3
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_req_o));

    // R4
    idle_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE && cur_idle) |=> (halt_req_o == '0));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !tick_i) |=> $stable(halt_req_o) && (halt_req_o != '0));

    // R6
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < CNT_W'(TIMEOUT_TICKS));

    // R7
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CHECK && !start_i) |=> $stable(fail_o));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |=> (halt_req_o == '0));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (halt_req_o == '0));
endmodule

bind bus_halt_ctrl bus_halt_ctrl_chk #(
    .NUM_PORTS     (NUM_PORTS),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .bus_idle_i (bus_idle_i),
    .halt_req_o (halt_req_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .state      (state_q),
    .port_idx   (port_idx_q),
    .wait_cnt   (wait_cnt)
);

// File: tb/bus_halt_ctrl_tb_top.sv
// Directed bench for bus_halt_ctrl: one task per scenario, with a port
// model that acknowledges after a set number of ticks.
module bus_halt_ctrl_tb_top;
    localparam int NP = 3;
    localparam int TO = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          tick = 1'b0;
    logic [NP-1:0] ack = '0;
    logic [NP-1:0] idle;
    logic [NP-1:0] req;
    logic          done;
    logic [NP-1:0] fail;

    // Port model configuration and observations.
    logic [NP-1:0] idle_init = '0;
    logic [NP-1:0] idle_after = '0;
    logic [NP-1:0] halted = '0;
    int            ack_lat [NP];
    int            seen [NP];
    int            hold_ticks [NP];
    int            order_log [8];
    int            n_rise = 0;
    logic [NP-1:0] req_prev = '0;
    int            div = 0;
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;

    always #5 clk = ~clk;

    bus_halt_ctrl #(.NUM_PORTS(NP), .TIMEOUT_TICKS(TO)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .tick_i     (tick),
        .halt_ack_i (ack),
        .bus_idle_i (idle),
        .halt_req_o (req),
        .done_o     (done),
        .fail_o     (fail)
    );

    assign idle = idle_init | (halted & idle_after);

    // Falling-edge model: tick divider, acknowledge, request logging.
    always @(negedge clk) begin
        cycles = cycles + 1;
        div = (div + 1) % 4;
        tick = (div == 0);
        for (int p = 0; p < NP; p++) begin
            if (req[p] && !req_prev[p]) begin
                if (n_rise < 8) order_log[n_rise] = p;
                n_rise = n_rise + 1;
            end
            if (req[p]) begin
                if (tick) begin
                    seen[p] = seen[p] + 1;
                    hold_ticks[p] = hold_ticks[p] + 1;
                end
                if (ack_lat[p] != 0 && seen[p] >= ack_lat[p]) begin
                    ack[p] = 1'b1;
                    halted[p] = 1'b1;
                end
            end else begin
                seen[p] = 0;
                ack[p] = 1'b0;
            end
        end
        req_prev = req;
    end

    task automatic check(input string rq, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic setup(input logic [NP-1:0] ii, input logic [NP-1:0] ia,
                         input int l0, input int l1, input int l2);
        @(negedge clk);
        idle_init = ii;
        idle_after = ia;
        halted = '0;
        ack_lat[0] = l0;
        ack_lat[1] = l1;
        ack_lat[2] = l2;
        n_rise = 0;
        for (int p = 0; p < NP; p++) hold_ticks[p] = 0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done;
        while (!done) begin
            @(negedge clk);
            if (cycles > 150000) begin
                errors = errors + 1;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
                summary();
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 req", int'(req), 0);
        check("R1 fail", int'(fail), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after release", int'(done), 0);
    endtask

    task automatic t_all_idle;
        setup(3'b111, 3'b000, 1, 1, 1);
        pulse_start();
        wait_done();
        check("R4 no request when all idle", n_rise, 0);
        check("R9 done all idle", int'(done), 1);
        check("R7 no fail all idle", int'(fail), 0);
    endtask

    task automatic t_normal;
        setup(3'b000, 3'b111, 2, 3, 1);
        pulse_start();
        check("R2 done cleared", int'(done), 0);
        wait_done();
        check("R3 request count", n_rise, 3);
        check("R3 first port", order_log[0], 0);
        check("R3 second port", order_log[1], 1);
        check("R3 third port", order_log[2], 2);
        check("R5 port0 held ticks", hold_ticks[0], 2);
        check("R5 port1 held ticks", hold_ticks[1], 3);
        check("R7 no fail on clean halt", int'(fail), 0);
        check("R8 requests cleared", int'(req), 0);
        repeat (5) @(negedge clk);
        check("R9 done holds", int'(done), 1);
    endtask

    task automatic t_timeout;
        setup(3'b000, 3'b111, 1, 0, 2);
        pulse_start();
        // Start while busy: must not restart the sequence.
        repeat (40) @(negedge clk);
        pulse_start();
        wait_done();
        check("R6 port1 timeout ticks", hold_ticks[1], TO);
        check("R6 port2 count restarts", hold_ticks[2], 2);
        check("R7 fail on port1 only", int'(fail), 2);
        check("R2 busy start ignored", n_rise, 3);
        check("R8 request dropped after timeout", int'(req), 0);
    endtask

    task automatic t_restart_clears;
        setup(3'b111, 3'b000, 1, 1, 1);
        check("R7 fail held until start", int'(fail), 2);
        pulse_start();
        check("R2 fail cleared by start", int'(fail), 0);
        wait_done();
    endtask

    task automatic t_ack_busy;
        setup(3'b000, 3'b011, 1, 1, 2);
        pulse_start();
        wait_done();
        check("R7 ack but busy fails", int'(fail), 4);
        check("R8 request cleared on fail", int'(req), 0);
    endtask

    task automatic t_mixed_skip;
        setup(3'b101, 3'b111, 1, 2, 1);
        pulse_start();
        wait_done();
        check("R4 only busy port requested", n_rise, 1);
        check("R4 requested port is 1", order_log[0], 1);
        check("R9 done after skip", int'(done), 1);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            ack_lat[p] = 0;
            seen[p] = 0;
            hold_ticks[p] = 0;
        end
        t_reset();
        t_all_idle();
        t_normal();
        t_timeout();
        t_restart_clears();
        t_ack_busy();
        t_mixed_skip();
        summary();
    end
endmodule